// File: doc/BRIEF.md
# IDE PIO Cycle Timing Sequencer

This block produces a single programmed-I/O transfer on an IDE channel each time it is asked to. A start pulse launches a cycle that walks through an optional address-setup interval, an interval with the read or write strobe driven low, and a recovery interval with both strobes high. Each interval lasts a number of clocks taken from timing fields that the surrounding register file provides. Drive 0 and drive 1 each have their own read fields and their own write fields. Byte-wide transfers ignore those fields and use one shared byte timing field.

When a cycle is accepted, the block selects the timing that applies to it and stores that timing with the direction. Later changes on the timing or control inputs therefore do not disturb a cycle that is already running. On a read, the data bus is captured on the last clock of the strobe-low interval. A one-clock done pulse marks the end of each cycle. `rst_n` is expected to be released synchronously to `clk` by the reset logic outside this block.

Top module: `ide_pio_seq`

## Requirements
- R1: While reset is applied and after it is released, both strobes are high, busy and done are low, and the read data register holds zero.
- R2: A timing byte gives the strobe-low clock count in bits 7..4 and the recovery clock count in bits 3..0.
- R3: For a 16-bit cycle, drive 0 takes `rd_tim0_i` for reads and `wr_tim0_i` for writes, and drive 1 takes `rd_tim1_i` for reads and `wr_tim1_i` for writes.
- R4: An 8-bit cycle (`byte_i`=1) takes its timing from `byte_tim_i`, whatever the drive and the direction.
- R5: The 2-bit setup field of the selected drive (`setup0_i` for drive 0, `setup1_i` for drive 1) sets the number of clocks with busy high and both strobes high before the strobe falls. A value of 0 gives no setup clocks.
- R6: A strobe-low count or recovery count of 0 lasts one clock.
- R7: A cycle runs setup, then strobe-low, then recovery. Only `dior_n_o` falls for a read (`write_i`=0), only `diow_n_o` falls for a write, and a strobe is never low while busy is low.
- R8: Busy rises on the clock after an accepted start and stays high through the last recovery clock. Done then goes high for exactly one clock while busy is low.
- R9: On a read, `rdata_o` takes the value of `dd_i` sampled at the clock edge that ends the final strobe-low clock. `rdata_o` changes at no other time.
- R10: A start while `enable_i` is 0 is ignored: busy stays low and no strobe falls.
- R11: A start while busy is high is ignored: the current cycle is unchanged and no extra cycle follows.
- R12: Drive, direction, width, timing and setup values are taken at the accepted start. Changes to them during the cycle have no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Channel enable; when 0, starts are refused |
| start_i | input | 1 | Request for one cycle |
| write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| drive_i | input | 1 | Drive select (0 or 1) |
| byte_i | input | 1 | 1 = 8-bit cycle using the byte timing |
| rd_tim0_i | input | 8 | Drive 0 read timing (active 7..4, recovery 3..0) |
| wr_tim0_i | input | 8 | Drive 0 write timing |
| rd_tim1_i | input | 8 | Drive 1 read timing |
| wr_tim1_i | input | 8 | Drive 1 write timing |
| byte_tim_i | input | 8 | Timing for 8-bit cycles |
| setup0_i | input | 2 | Drive 0 address setup clocks |
| setup1_i | input | 2 | Drive 1 address setup clocks |
| dd_i | input | 16 | Device data bus input |
| dior_n_o | output | 1 | Read strobe, active low |
| diow_n_o | output | 1 | Write strobe, active low |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock end-of-cycle pulse |
| rdata_o | output | 16 | Data captured from the last read |

## Verification
The assertions check on every clock that the two strobes are never low together, that a strobe is low only while busy, that done is a single clock following busy, that an accepted start raises busy, that a disabled channel stays idle, and that the read data changes only right after a read strobe clock. The exact lengths of the setup, strobe-low and recovery intervals, the choice among the five timing fields, the zero-count rule, the sample point of the read data and the immunity to mid-cycle input changes can only be shown by the bench scenarios. There, a scoreboard measures each cycle at the pins and compares it with the intervals computed from the programmed fields.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_ACTIVE  = 2'd2,
    PH_RECOVER = 2'd3
  } ide_phase_e;

endpackage

// File: rtl/ide_pio_timsel.sv
module ide_pio_timsel #(
  parameter int CNT_W   = 4,
  parameter int SETUP_W = 2,
  localparam int TIM_W  = 2 * CNT_W
) (
  input  logic               drive_i,
  input  logic               write_i,
  input  logic               byte_i,
  input  logic [TIM_W-1:0]   rd_tim0_i,
  input  logic [TIM_W-1:0]   wr_tim0_i,
  input  logic [TIM_W-1:0]   rd_tim1_i,
  input  logic [TIM_W-1:0]   wr_tim1_i,
  input  logic [TIM_W-1:0]   byte_tim_i,
  input  logic [SETUP_W-1:0] setup0_i,
  input  logic [SETUP_W-1:0] setup1_i,
  output logic [CNT_W-1:0]   act_m1_o,
  output logic [CNT_W-1:0]   rec_m1_o,
  output logic [SETUP_W-1:0] setup_o
);

  logic [TIM_W-1:0] word_tim;
  logic [TIM_W-1:0] sel_tim;
  logic [CNT_W-1:0] act_cnt;
  logic [CNT_W-1:0] rec_cnt;

  always_comb begin
    if (drive_i) word_tim = write_i ? wr_tim1_i : rd_tim1_i;
    else         word_tim = write_i ? wr_tim0_i : rd_tim0_i;
    sel_tim = byte_i ? byte_tim_i : word_tim;
  end

  assign act_cnt = sel_tim[TIM_W-1:CNT_W];
  assign rec_cnt = sel_tim[CNT_W-1:0];

  // A zero count still occupies one clock; loaded value is length minus one.
  assign act_m1_o = (act_cnt == '0) ? '0 : act_cnt - 1'b1;
  assign rec_m1_o = (rec_cnt == '0) ? '0 : rec_cnt - 1'b1;
  assign setup_o  = drive_i ? setup1_i : setup0_i;

endmodule

// File: rtl/ide_pio_phase_ctr.sv
module ide_pio_phase_ctr #(
  parameter int CTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CTR_W-1:0] load_val_i,
  output logic             last_o
);

  logic [CTR_W-1:0] cnt_q;
  logic [CTR_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i | (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == '0);

endmodule

// File: rtl/ide_pio_rdlatch.sv
module ide_pio_rdlatch #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en_i,
  input  logic [DATA_W-1:0] dd_i,
  output logic [DATA_W-1:0] rdata_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_o <= '0;
    else if (cap_en_i) rdata_o <= dd_i;
  end

endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
  import ide_pio_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 4,
  parameter int SETUP_W = 2,
  localparam int TIM_W  = 2 * CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable_i,
  input  logic               start_i,
  input  logic               write_i,
  input  logic               drive_i,
  input  logic               byte_i,
  input  logic [TIM_W-1:0]   rd_tim0_i,
  input  logic [TIM_W-1:0]   wr_tim0_i,
  input  logic [TIM_W-1:0]   rd_tim1_i,
  input  logic [TIM_W-1:0]   wr_tim1_i,
  input  logic [TIM_W-1:0]   byte_tim_i,
  input  logic [SETUP_W-1:0] setup0_i,
  input  logic [SETUP_W-1:0] setup1_i,
  input  logic [DATA_W-1:0]  dd_i,
  output logic               dior_n_o,
  output logic               diow_n_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [DATA_W-1:0]  rdata_o
);

  localparam int CTR_W = (CNT_W > SETUP_W) ? CNT_W : SETUP_W;

  ide_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] sel_act_m1, sel_rec_m1;
  logic [SETUP_W-1:0] sel_setup;
  logic [CNT_W-1:0] cap_act_m1_q, cap_rec_m1_q;
  logic             cap_write_q;
  logic             accept;
  logic             ctr_load;
  logic [CTR_W-1:0] ctr_val;
  logic             ctr_last;
  logic             done_d, done_q;
  logic             rd_cap_en;

  ide_pio_timsel #(.CNT_W(CNT_W), .SETUP_W(SETUP_W)) u_timsel (
    .drive_i   (drive_i),
    .write_i   (write_i),
    .byte_i    (byte_i),
    .rd_tim0_i (rd_tim0_i),
    .wr_tim0_i (wr_tim0_i),
    .rd_tim1_i (rd_tim1_i),
    .wr_tim1_i (wr_tim1_i),
    .byte_tim_i(byte_tim_i),
    .setup0_i  (setup0_i),
    .setup1_i  (setup1_i),
    .act_m1_o  (sel_act_m1),
    .rec_m1_o  (sel_rec_m1),
    .setup_o   (sel_setup)
  );

  assign accept = (phase_q == PH_IDLE) & start_i & enable_i;

  // Cycle configuration held for the whole transfer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_act_m1_q <= '0;
      cap_rec_m1_q <= '0;
      cap_write_q  <= 1'b0;
    end else if (accept) begin
      cap_act_m1_q <= sel_act_m1;
      cap_rec_m1_q <= sel_rec_m1;
      cap_write_q  <= write_i;
    end
  end

  // Next phase, counter reload and done strobe.
  always_comb begin
    phase_d  = phase_q;
    ctr_load = 1'b0;
    ctr_val  = '0;
    done_d   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          ctr_load = 1'b1;
          if (sel_setup != '0) begin
            phase_d = PH_SETUP;
            ctr_val = CTR_W'(sel_setup - 1'b1);
          end else begin
            phase_d = PH_ACTIVE;
            ctr_val = CTR_W'(sel_act_m1);
          end
        end
      end
      PH_SETUP: begin
        if (ctr_last) begin
          phase_d  = PH_ACTIVE;
          ctr_load = 1'b1;
          ctr_val  = CTR_W'(cap_act_m1_q);
        end
      end
      PH_ACTIVE: begin
        if (ctr_last) begin
          phase_d  = PH_RECOVER;
          ctr_load = 1'b1;
          ctr_val  = CTR_W'(cap_rec_m1_q);
        end
      end
      PH_RECOVER: begin
        if (ctr_last) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  ide_pio_phase_ctr #(.CTR_W(CTR_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (ctr_load),
    .load_val_i(ctr_val),
    .last_o    (ctr_last)
  );

  assign rd_cap_en = (phase_q == PH_ACTIVE) & ctr_last & ~cap_write_q;

  ide_pio_rdlatch #(.DATA_W(DATA_W)) u_rdlatch (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en_i(rd_cap_en),
    .dd_i    (dd_i),
    .rdata_o (rdata_o)
  );

  assign dior_n_o = ~((phase_q == PH_ACTIVE) & ~cap_write_q);
  assign diow_n_o = ~((phase_q == PH_ACTIVE) &  cap_write_q);
  assign busy_o   = (phase_q != PH_IDLE);
  assign done_o   = done_q;

endmodule

// File: rtl/ide_pio_seq_chk.sv
module ide_pio_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable_i,
  input logic              start_i,
  input logic              dior_n_o,
  input logic              diow_n_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] rdata_o
);

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dior_n_o | diow_n_o));

  p_strobe_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dior_n_o || !diow_n_o) |-> busy_o);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  p_start_raises_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && enable_i && !busy_o) |=> busy_o);

  p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !enable_i) |=> !busy_o);

  p_rdata_only_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata_o) |-> !$past(dior_n_o));

endmodule

bind ide_pio_seq ide_pio_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .enable_i(enable_i),
  .start_i (start_i),
  .dior_n_o(dior_n_o),
  .diow_n_o(diow_n_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .rdata_o (rdata_o)
);

// File: tb/ide_pio_seq_test.sv
module ide_pio_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] DD_BASE = 16'h5000;

  typedef struct {
    int          s;
    int          a;
    int          r;
    bit          wr;
    logic [15:0] rd;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable_i, start_i, write_i, drive_i, byte_i;
  logic [7:0]  rd_tim0_i, wr_tim0_i, rd_tim1_i, wr_tim1_i, byte_tim_i;
  logic [1:0]  setup0_i, setup1_i;
  logic [15:0] dd_i;
  logic        dior_n_o, diow_n_o, busy_o, done_o;
  logic [15:0] rdata_o;

  int   checks = 0;
  int   fails  = 0;
  exp_t sb_q[$];

  ide_pio_seq uut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .start_i(start_i),
    .write_i(write_i), .drive_i(drive_i), .byte_i(byte_i),
    .rd_tim0_i(rd_tim0_i), .wr_tim0_i(wr_tim0_i),
    .rd_tim1_i(rd_tim1_i), .wr_tim1_i(wr_tim1_i),
    .byte_tim_i(byte_tim_i), .setup0_i(setup0_i), .setup1_i(setup1_i),
    .dd_i(dd_i), .dior_n_o(dior_n_o), .diow_n_o(diow_n_o),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Monitor: measures each cycle at the pins and scores it on done.
  int mon_s = 0, mon_a = 0, mon_r = 0;
  bit mon_rd = 0, mon_wr = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_o) begin
        if (!dior_n_o || !diow_n_o) begin
          mon_a++;
          if (!dior_n_o) mon_rd = 1;
          if (!diow_n_o) mon_wr = 1;
          dd_i = DD_BASE + 16'(mon_a);
        end else if (mon_a == 0) mon_s++;
        else mon_r++;
      end
      if (done_o) begin
        if (sb_q.size() == 0) begin
          chk(0, "R11", "unexpected cycle completed", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(mon_s == e.s, "R5", "setup clocks", mon_s, e.s);
          chk(mon_a == e.a, "R2 R3 R4 R6", "strobe-low clocks", mon_a, e.a);
          chk(mon_r == e.r, "R2 R3 R4 R6", "recovery clocks", mon_r, e.r);
          chk((mon_wr == e.wr) && (mon_rd == !e.wr), "R7", "strobe direction (wr)",
              int'(mon_wr), int'(e.wr));
          if (!e.wr)
            chk(rdata_o == e.rd, "R9", "read data", int'(rdata_o), int'(e.rd));
          chk(!busy_o, "R8", "busy low with done", int'(busy_o), 0);
        end
        mon_s = 0; mon_a = 0; mon_r = 0; mon_rd = 0; mon_wr = 0;
      end
    end
  end

  // mode: 0 plain, 1 change inputs after start (R12), 2 extra start while busy (R11)
  task automatic issue(input bit drv, input bit wr, input bit nar,
                       input logic [3:0] a, input logic [3:0] r,
                       input logic [1:0] s, input int mode);
    exp_t e;
    @(negedge clk);
    rd_tim0_i = 8'h9C; wr_tim0_i = 8'h9C; rd_tim1_i = 8'h9C;
    wr_tim1_i = 8'h9C; byte_tim_i = 8'h9C;
    setup0_i = drv ? ~s : s;
    setup1_i = drv ? s : ~s;
    if (nar) byte_tim_i = {a, r};
    else if (!drv && !wr) rd_tim0_i = {a, r};
    else if (!drv &&  wr) wr_tim0_i = {a, r};
    else if ( drv && !wr) rd_tim1_i = {a, r};
    else                  wr_tim1_i = {a, r};
    drive_i = drv; write_i = wr; byte_i = nar;
    e.s  = int'(s);
    e.a  = (a == 0) ? 1 : int'(a);
    e.r  = (r == 0) ? 1 : int'(r);
    e.wr = wr;
    e.rd = DD_BASE + 16'(e.a);
    sb_q.push_back(e);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (mode == 1) begin
      rd_tim0_i = 8'h11; wr_tim0_i = 8'h11; rd_tim1_i = 8'h11;
      wr_tim1_i = 8'h11; byte_tim_i = 8'h11;
      setup0_i = 2'd0; setup1_i = 2'd0;
      drive_i = ~drv; write_i = ~wr; byte_i = ~nar;
    end
    if (mode == 2) begin
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R8", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; enable_i = 1'b1; start_i = 1'b0; write_i = 1'b0;
    drive_i = 1'b0; byte_i = 1'b0; dd_i = '0;
    rd_tim0_i = '0; wr_tim0_i = '0; rd_tim1_i = '0; wr_tim1_i = '0;
    byte_tim_i = '0; setup0_i = '0; setup1_i = '0;
    repeat (3) @(negedge clk);
    chk(dior_n_o && diow_n_o && !busy_o && !done_o && rdata_o == 0,
        "R1", "state in reset", int'({dior_n_o, diow_n_o, busy_o, done_o}), 12);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dior_n_o && diow_n_o && !busy_o && !done_o && rdata_o == 0,
        "R1", "state after reset", int'({dior_n_o, diow_n_o, busy_o, done_o}), 12);

    issue(0, 0, 0, 4'd5, 4'd3, 2'd2, 0);   // R3 drive 0 read
    issue(0, 1, 0, 4'd4, 4'd6, 2'd0, 0);   // R3 drive 0 write, R5 zero setup
    issue(1, 0, 0, 4'd7, 4'd2, 2'd3, 0);   // R3 drive 1 read
    issue(1, 1, 0, 4'd2, 4'd1, 2'd1, 0);   // R3 drive 1 write
    issue(0, 0, 1, 4'd3, 4'd4, 2'd1, 0);   // R4 byte read
    issue(1, 1, 1, 4'd6, 4'd2, 2'd0, 0);   // R4 byte write
    issue(0, 0, 0, 4'd0, 4'd0, 2'd0, 0);   // R6 zero counts
    issue(1, 0, 0, 4'd15, 4'd15, 2'd3, 0); // R2 largest counts
    issue(0, 0, 0, 4'd6, 4'd5, 2'd2, 1);   // R12 inputs changed mid-cycle
    issue(1, 1, 0, 4'd5, 4'd4, 2'd1, 2);   // R11 start while busy

    // R11: no trailing cycle after the re-pulsed start
    repeat (3) begin
      @(negedge clk);
      chk(!busy_o && dior_n_o && diow_n_o, "R11", "idle after ignored start",
          int'(busy_o), 0);
    end

    // R10: start with channel disabled
    @(negedge clk);
    enable_i = 1'b0; start_i = 1'b1; setup0_i = 2'd0; drive_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) begin
      chk(!busy_o && dior_n_o && diow_n_o && !done_o, "R10",
          "no cycle while disabled", int'(busy_o), 0);
      @(negedge clk);
    end
    enable_i = 1'b1;
    issue(0, 1, 0, 4'd1, 4'd1, 2'd0, 0);   // R8 back-to-back after re-enable

    repeat (2) @(negedge clk);
    chk(sb_q.size() == 0, "R8", "every started cycle completed", sb_q.size(), 0);
    finish_run();
  end

endmodule